// File: doc/BRIEF.md
# Posted Write Buffer with Deferred Bus Request

This block collects write data from a local master and holds it until a system-bus engine drains it. Words enter through a push port and leave through a show-ahead pop port. The storage is 32 entries deep and 32 bits wide. The block keeps an entry count. From that count it drives an active-low almost-full pin against a programmable threshold.

The first accepted word of a local burst starts the block's request logic. The block raises a bus request after a programmable wait of 0, 4, 8 or 16 clocks. In line mode it also holds the request until a whole cache-line-sized burst of 8 or 16 words has been pushed. Once the bus grants, the request stays up until the buffer is empty and the local burst has closed. The address of the first word of each burst is latched and presented next to the request.

Misuse is reported by two sticky flags. One marks a push into a full buffer. The other marks a line-mode burst that closed at the wrong length. Both clear only on reset.

Top module: `pwb_top`

## Requirements
- R1: Words leave in the order they were pushed. `rd_data` always shows the oldest stored word. `fifo_empty` is 1 exactly when no word is stored. The buffer holds up to 32 words.
- R2: `af_n` is 0 when the stored-word count is strictly greater than `cfg_af_thresh` (5 bits). Otherwise it is 1.
- R3: A push while 32 words are stored is dropped and the stored contents are unchanged. It sets `overflow`, which stays 1 until reset.
- R4: A pop while the buffer is empty is ignored. The read position does not move, so the next pushed word is the next word read.
- R5: A burst starts with an accepted push while no burst is open. A burst closes with an accepted push that has `wr_last`=1. With `cfg_delay` codes 0, 1, 2, 3, `bus_req` goes high 1, 5, 9 or 17 clock edges after the edge that accepted the burst's first word. This is a wait of 0, 4, 8 or 16 clocks beyond the minimum.
- R6: With `cfg_line_mode`=1, `bus_req` is not raised while the open burst holds fewer words than the line length. The line length is 16 when `cfg_line16`=1 and 8 when it is 0.
- R7: With `cfg_line_mode`=1, a burst that closes with a word count other than the line length sets `burst_err`, which stays 1 until reset. With `cfg_line_mode`=0, no burst length sets it.
- R8: A grant (`bus_gnt`=1 while `bus_req`=1) clears the wait counter and the pending start. After that, `bus_req` stays 1 while words remain or a burst is open. It falls one edge after the buffer is empty and no burst is open.
- R9: `req_addr` holds the `wr_addr` value of the first word of the most recent burst.
- R10: After reset, `fifo_empty`=1, `af_n`=1, `bus_req`=0, `overflow`=0 and `burst_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_af_thresh | input | 5 | Almost-full threshold |
| cfg_delay | input | 2 | Request wait code (0/4/8/16 clocks) |
| cfg_line_mode | input | 1 | Hold request for a full line-sized burst |
| cfg_line16 | input | 1 | Line length: 1 = 16 words, 0 = 8 words |
| wr_en | input | 1 | Push strobe |
| wr_data | input | 32 | Push data |
| wr_last | input | 1 | Pushed word closes the burst |
| wr_addr | input | 32 | Address presented with the pushed word |
| rd_en | input | 1 | Pop strobe |
| rd_data | output | 32 | Oldest stored word (show-ahead) |
| fifo_empty | output | 1 | No word stored |
| af_n | output | 1 | Almost full, active low |
| overflow | output | 1 | Sticky: push into full buffer |
| burst_err | output | 1 | Sticky: line-mode burst of wrong length |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| req_addr | output | 32 | Start address of the latest burst |

## Verification
The bench measures the request latency for every wait code, counting edges from the first push. A counter that starts late, or that restarts on every word, shows up as an off-by-N latency. It fills the buffer to exactly 32 words, pushes once more and drains. A design that overwrites the head or wraps the count returns a wrong word or an extra word. It pops on an empty buffer and then pushes one marker word, which exposes a read pointer that moved. In line mode it looks at the request after 8 of 16 words. A design that confused the two line lengths, or ignored the gate, would already be requesting. It closes short bursts both in and out of line mode to catch an error flag raised in the wrong mode.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  // Clocks of extra wait selected by the two-bit request delay code.
  function automatic logic [4:0] delay_clocks(input logic [1:0] code);
    case (code)
      2'd0:    delay_clocks = 5'd0;
      2'd1:    delay_clocks = 5'd4;
      2'd2:    delay_clocks = 5'd8;
      default: delay_clocks = 5'd16;
    endcase
  endfunction

  // Words in one cache line as picked by the line-size select.
  function automatic logic [4:0] line_words(input logic sel16);
    line_words = sel16 ? 5'd16 : 5'd8;
  endfunction
endpackage

// File: rtl/pwb_fifo.sv
module pwb_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 32,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full,
  output logic          push_ok,
  output logic          pop_ok,
  output logic          ovf
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, rptr;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    bump = (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      if (push_ok) wptr <= bump(wptr);
      if (pop_ok)  rptr <= bump(rptr);
      count <= count + CW'(push_ok) - CW'(pop_ok);
      if (push && full) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/pwb_burst.sv
module pwb_burst #(
  parameter int AW   = 32,
  parameter int LENW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_ok,
  input  logic            last,
  input  logic [AW-1:0]   addr,
  input  logic            line_mode,
  input  logic            line16,
  output logic            first,
  output logic            active,
  output logic [LENW-1:0] len,
  output logic            err,
  output logic [AW-1:0]   start_addr
);
  import pwb_pkg::*;

  logic [LENW-1:0] len_inc;

  assign active  = (len != '0);
  assign first   = push_ok && !active;
  assign len_inc = (len == '1) ? len : len + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len        <= '0;
      err        <= 1'b0;
      start_addr <= '0;
    end else if (push_ok) begin
      if (first) start_addr <= addr;
      if (last) begin
        len <= '0;
        if (line_mode && (len_inc != LENW'(line_words(line16)))) err <= 1'b1;
      end else begin
        len <= len_inc;
      end
    end
  end
endmodule

// File: rtl/pwb_req.sv
module pwb_req #(
  parameter int LENW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            burst_first,
  input  logic            burst_active,
  input  logic [LENW-1:0] burst_len,
  input  logic            fifo_empty,
  input  logic            bus_gnt,
  input  logic [1:0]      delay_code,
  input  logic            line_mode,
  input  logic            line16,
  output logic            bus_req,
  output logic            raise,
  output logic            dly_done
);
  import pwb_pkg::*;

  logic       pend;
  logic [4:0] dly_cnt;
  logic       gate_ok, drop;

  assign dly_done = (dly_cnt >= delay_clocks(delay_code));
  assign gate_ok  = !line_mode || !burst_active ||
                    (burst_len >= LENW'(line_words(line16)));
  assign raise    = pend && dly_done && gate_ok;
  assign drop     = fifo_empty && !burst_active && !pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= 1'b0;
      dly_cnt <= '0;
      bus_req <= 1'b0;
    end else begin
      if (burst_first) begin
        pend    <= 1'b1;
        dly_cnt <= '0;
      end else if (bus_gnt && bus_req) begin
        pend    <= 1'b0;
        dly_cnt <= '0;
      end else if (pend && !dly_done) begin
        dly_cnt <= dly_cnt + 1'b1;
      end
      if (raise)     bus_req <= 1'b1;
      else if (drop) bus_req <= 1'b0;
    end
  end
endmodule

// File: rtl/pwb_top.sv
module pwb_top #(
  parameter int DW    = 32,
  parameter int AW    = 32,
  parameter int DEPTH = 32,
  localparam int TW   = $clog2(DEPTH),
  localparam int CW   = TW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] cfg_af_thresh,
  input  logic [1:0]    cfg_delay,
  input  logic          cfg_line_mode,
  input  logic          cfg_line16,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_last,
  input  logic [AW-1:0] wr_addr,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          fifo_empty,
  output logic          af_n,
  output logic          overflow,
  output logic          burst_err,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic [AW-1:0] req_addr
);
  logic [CW-1:0] count;
  logic          fifo_full, push_ok, pop_ok;
  logic          burst_first, burst_active;
  logic [CW-1:0] burst_len;
  logic          raise_w, dly_done_w;

  pwb_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(wr_en), .pop(rd_en), .din(wr_data),
    .dout(rd_data), .count(count), .empty(fifo_empty), .full(fifo_full),
    .push_ok(push_ok), .pop_ok(pop_ok), .ovf(overflow)
  );

  pwb_burst #(.AW(AW), .LENW(CW)) u_burst (
    .clk(clk), .rst_n(rst_n), .push_ok(push_ok), .last(wr_last),
    .addr(wr_addr), .line_mode(cfg_line_mode), .line16(cfg_line16),
    .first(burst_first), .active(burst_active), .len(burst_len),
    .err(burst_err), .start_addr(req_addr)
  );

  pwb_req #(.LENW(CW)) u_req (
    .clk(clk), .rst_n(rst_n), .burst_first(burst_first),
    .burst_active(burst_active), .burst_len(burst_len),
    .fifo_empty(fifo_empty), .bus_gnt(bus_gnt), .delay_code(cfg_delay),
    .line_mode(cfg_line_mode), .line16(cfg_line16),
    .bus_req(bus_req), .raise(raise_w), .dly_done(dly_done_w)
  );

  assign af_n = !(count > CW'(cfg_af_thresh));
endmodule

// File: rtl/pwb_top_chk.sv
module pwb_top_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic rd_en,
  input logic fifo_empty,
  input logic fifo_full,
  input logic pop_ok,
  input logic af_n,
  input logic overflow,
  input logic burst_err,
  input logic bus_req,
  input logic raise_w,
  input logic dly_done_w
);
  // R2: almost-full can only be signalled when something is stored
  a_r2_af_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    !af_n |-> !fifo_empty);
  // R3
  a_r3_full_push_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && fifo_full) |=> overflow);
  a_r3_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  // R4
  a_r4_empty_pop_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_empty && rd_en && !wr_en) |=> fifo_empty);
  a_r4_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok |-> !fifo_empty);
  // R5, R6: a rising request follows a cycle where the wait and gate allowed it
  a_r5_rise_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> $past(raise_w && dly_done_w));
  // R7
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    burst_err |=> burst_err);
  // R8: request falls only after the buffer was empty
  a_r8_drop_on_empty: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_req) |-> $past(fifo_empty));
endmodule

bind pwb_top pwb_top_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
  .fifo_empty(fifo_empty), .fifo_full(fifo_full), .pop_ok(pop_ok),
  .af_n(af_n), .overflow(overflow), .burst_err(burst_err),
  .bus_req(bus_req), .raise_w(raise_w), .dly_done_w(dly_done_w)
);

// File: tb/pwb_top_test.sv
module pwb_top_test;
  localparam time TCLK = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  cfg_af_thresh;
  logic [1:0]  cfg_delay;
  logic        cfg_line_mode, cfg_line16;
  logic        wr_en, wr_last, rd_en, bus_gnt;
  logic [31:0] wr_data, wr_addr;
  logic [31:0] rd_data, req_addr;
  logic        fifo_empty, af_n, overflow, burst_err, bus_req;

  int checks = 0;
  int errors = 0;

  always #(TCLK/2) clk = ~clk;

  pwb_top uut (
    .clk(clk), .rst_n(rst_n), .cfg_af_thresh(cfg_af_thresh),
    .cfg_delay(cfg_delay), .cfg_line_mode(cfg_line_mode),
    .cfg_line16(cfg_line16), .wr_en(wr_en), .wr_data(wr_data),
    .wr_last(wr_last), .wr_addr(wr_addr), .rd_en(rd_en), .rd_data(rd_data),
    .fifo_empty(fifo_empty), .af_n(af_n), .overflow(overflow),
    .burst_err(burst_err), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .req_addr(req_addr)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic do_reset();
    rst_n = 1'b0;
    cfg_af_thresh = '0; cfg_delay = '0; cfg_line_mode = 0; cfg_line16 = 0;
    wr_en = 0; wr_last = 0; wr_data = '0; wr_addr = '0; rd_en = 0; bus_gnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic push_word(input logic [31:0] d, input bit last,
                           input logic [31:0] a);
    wr_en = 1; wr_data = d; wr_last = last; wr_addr = a;
    @(negedge clk);
    wr_en = 0; wr_last = 0;
  endtask

  task automatic pop_word(output logic [31:0] d);
    d = rd_data;
    rd_en = 1;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic t_reset_state();
    do_reset();
    check(fifo_empty == 1 && af_n == 1 && bus_req == 0 && overflow == 0 &&
          burst_err == 0, "R10 reset outputs",
          {27'd0, fifo_empty, af_n, bus_req, overflow, burst_err}, 32'h18);
  endtask

  task automatic t_order_and_overflow();
    logic [31:0] d;
    do_reset();
    for (int i = 0; i < 32; i++) push_word(32'hA000 + i, 0, 32'h0);
    check(overflow == 0, "R3 no overflow at exactly 32", overflow, 0);
    push_word(32'hDEAD, 1, 32'h0);
    check(overflow == 1, "R3 overflow set on full push", overflow, 1);
    for (int i = 0; i < 32; i++) begin
      pop_word(d);
      check(d == 32'hA000 + i, "R1 order / R3 dropped word", d, 32'hA000 + i);
    end
    check(fifo_empty == 1, "R1 empty after drain", fifo_empty, 1);
    check(overflow == 1, "R3 overflow sticky", overflow, 1);
  endtask

  task automatic t_empty_pop();
    logic [31:0] d;
    do_reset();
    rd_en = 1; @(negedge clk); @(negedge clk); rd_en = 0;
    check(fifo_empty == 1 && af_n == 1, "R4 pop on empty ignored",
          {fifo_empty, af_n}, 2'b11);
    push_word(32'h1234_5678, 1, 32'h0);
    push_word(32'h9ABC_DEF0, 1, 32'h0);
    pop_word(d);
    check(d == 32'h1234_5678, "R4 read position kept", d, 32'h1234_5678);
    pop_word(d);
    check(d == 32'h9ABC_DEF0, "R1 second word", d, 32'h9ABC_DEF0);
  endtask

  task automatic t_almost_full();
    do_reset();
    cfg_af_thresh = 5'd3;
    for (int i = 0; i < 3; i++) push_word(i, 0, 0);
    check(af_n == 1, "R2 count equal to threshold", af_n, 1);
    push_word(32'h3, 0, 0);
    check(af_n == 0, "R2 count above threshold", af_n, 0);
    do_reset();
    cfg_af_thresh = 5'd31;
    for (int i = 0; i < 31; i++) push_word(i, 0, 0);
    check(af_n == 1, "R2 threshold 31 at 31 words", af_n, 1);
    push_word(32'h1F, 0, 0);
    check(af_n == 0, "R2 threshold 31 at 32 words", af_n, 0);
    do_reset();
    push_word(32'h5, 1, 0);
    check(af_n == 0, "R2 threshold 0 with one word", af_n, 0);
  endtask

  task automatic t_delay(input logic [1:0] code);
    int k = 0;
    int exp_k;
    do_reset();
    cfg_delay = code;
    exp_k = 1 + ((code == 0) ? 0 : (4 << (code - 1)));
    push_word(32'h77, 1, 0);
    while (!bus_req && k < 40) begin
      @(negedge clk);
      k++;
    end
    check(k == exp_k, $sformatf("R5 request latency code %0d", code), k, exp_k);
  endtask

  task automatic t_line_mode(input bit sel16);
    int n = sel16 ? 16 : 8;
    do_reset();
    cfg_line_mode = 1; cfg_line16 = sel16;
    for (int i = 0; i < n - 1; i++) begin
      push_word(i, 0, 0);
      if (i == 7) check(bus_req == 0, "R6 held at 8 of 16 words", bus_req, 0);
    end
    @(negedge clk);
    check(bus_req == 0, $sformatf("R6 held one short of %0d", n), bus_req, 0);
    push_word(n - 1, 1, 0);
    @(negedge clk);
    check(bus_req == 1, $sformatf("R6 raised after %0d words", n), bus_req, 1);
    check(burst_err == 0, "R7 exact line length no error", burst_err, 0);
  endtask

  task automatic t_burst_err();
    do_reset();
    for (int i = 0; i < 5; i++) push_word(i, i == 4, 0);
    check(burst_err == 0, "R7 short burst outside line mode", burst_err, 0);
    do_reset();
    cfg_line_mode = 1;
    for (int i = 0; i < 5; i++) push_word(i, i == 4, 0);
    check(burst_err == 1, "R7 short burst in line mode", burst_err, 1);
    push_word(9, 1, 0);
    check(burst_err == 1, "R7 error sticky", burst_err, 1);
  endtask

  task automatic t_grant_drop();
    logic [31:0] d;
    do_reset();
    for (int i = 0; i < 3; i++) push_word(i, i == 2, 0);
    check(bus_req == 1, "R8 request up", bus_req, 1);
    bus_gnt = 1; @(negedge clk); bus_gnt = 0;
    pop_word(d); pop_word(d);
    check(bus_req == 1, "R8 holds while data remains", bus_req, 1);
    pop_word(d);
    check(bus_req == 1, "R8 still up on the emptying edge", bus_req, 1);
    @(negedge clk);
    check(bus_req == 0, "R8 drops after drain", bus_req, 0);
  endtask

  task automatic t_start_addr();
    do_reset();
    push_word(1, 0, 32'h4000_0100);
    push_word(2, 0, 32'h4000_0104);
    push_word(3, 1, 32'h4000_0108);
    check(req_addr == 32'h4000_0100, "R9 first address kept", req_addr, 32'h4000_0100);
    push_word(4, 0, 32'h8000_0200);
    push_word(5, 1, 32'h8000_0204);
    check(req_addr == 32'h8000_0200, "R9 next burst address", req_addr, 32'h8000_0200);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset_state();
    t_order_and_overflow();
    t_empty_pop();
    t_almost_full();
    for (int c = 0; c < 4; c++) t_delay(2'(c));
    t_line_mode(0);
    t_line_mode(1);
    t_burst_err();
    t_grant_drop();
    t_start_addr();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule